// File: doc/BRIEF.md
# Real-Time Clock Alarm and Periodic Interrupt Controller

This block merges three interrupt sources of a real-time clock onto one active-low, open-drain request line. Two identical alarm channels each hold a minute, an hour and a seven-bit weekday mask. Each channel compares these registers with the running time on the strobe that marks a new minute. A periodic source raises its request on a selectable strobe from the counter chain. The strobe can come every half second, every second, every minute, every hour or every month. The two fastest settings give single-cycle pulses and the others give a level.

Every source owns a sticky flag that the host clears through a small register port. The line is modelled as a drive-low enable: when it is 1 the pad pulls low, and when it is 0 the pad floats. The pad is never driven high. Time counting and the serial host bus sit outside the block, which only sees the current time fields, the timing strobes and a flat register port.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: Reset forces `irq_drive_low_o` to 0 (line released). Reset also clears every register and flag, so that every address reads 0.
- R2: Register map with combinational readback:
  - address 0 holds alarm A minute (BCD, 7 bits), address 1 holds the A hour (BCD, 6 bits) and address 2 holds the A weekday mask (7 bits).
  - addresses 3, 4 and 5 hold the same three registers for alarm B.
  - address 6 is control: bit 0 enables alarm A, bit 1 enables alarm B, bit 2 halts the periodic source, and bits 6:4 hold the periodic mode.
  - address 7 holds the flags: bit 0 alarm A, bit 1 alarm B, bit 2 periodic.
- R3: An enabled alarm flag sets at the clock edge that samples `min_tick_i` high, but only when `min_i` equals its minute register and `hour_i` equals its hour register. Without `min_tick_i` it never sets.
- R4: Weekday mask bit k accepts `wday_i` = k (0 to 6). Several bits may be set to accept several weekdays.
- R5: The two alarm channels are independent, and a channel whose enable bit is 0 never sets its flag.
- R6: Flags are sticky. A write to address 7 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1.
- R7: `irq_drive_low_o` is 1 exactly when an enabled alarm has its flag set or the periodic source requests. Clearing an alarm enable releases the line but keeps the flag.
- R8: Periodic mode codes:
  - 1 selects the half-second strobe as a pulse.
  - 2 selects the second strobe as a pulse.
  - 3 selects the second strobe as a level.
  - 4 selects the minute strobe as a level.
  - 5 selects the hour strobe as a level.
  - 6 selects the month strobe as a level.
  - 0 and 7 never fire.
- R9: In pulse modes, the line is driven low for exactly the one cycle after the selected strobe, and the periodic flag also sets. In level modes, the line stays low until the flag is cleared.
- R10: With the halt bit set, the periodic source never drives the line, but its flag still sets. Releasing halt while a level-mode flag is set drives the line.
- R11: A flag set event and a host clear of that flag in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_tick_i | input | 1 | One-cycle strobe every half second |
| sec_tick_i | input | 1 | One-cycle strobe every second |
| min_tick_i | input | 1 | One-cycle strobe when seconds roll to 00 |
| hour_tick_i | input | 1 | One-cycle strobe on each new hour |
| month_tick_i | input | 1 | One-cycle strobe on each new month |
| min_i | input | 7 | Current minute, BCD |
| hour_i | input | 6 | Current hour, BCD |
| wday_i | input | 3 | Current weekday, 0 to 6 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational |
| irq_drive_low_o | output | 1 | 1 pulls the interrupt line low, 0 releases it |

## Verification
Flags, control and alarm registers all update at the clock edge that samples the strobe or write. The interrupt output and the read data follow from registered state combinationally, so each result is due one edge after its stimulus. A pulse-mode request is visible only in that one cycle. The bench drives inputs at the falling edge and records the edge index at which each expectation is due. A monitor samples a quarter period after that rising edge, which places every check in the single cycle where the result must hold. Checks that follow the pulse cycle confirm that the line is released again.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  typedef enum logic [2:0] {
    PER_OFF         = 3'd0,
    PER_HALF_PULSE  = 3'd1,
    PER_SEC_PULSE   = 3'd2,
    PER_SEC_LEVEL   = 3'd3,
    PER_MIN_LEVEL   = 3'd4,
    PER_HOUR_LEVEL  = 3'd5,
    PER_MONTH_LEVEL = 3'd6,
    PER_RSVD        = 3'd7
  } per_mode_e;

  localparam int unsigned ADDR_W    = 3;
  localparam int unsigned REGS_PER_ALARM = 3;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd6;
  localparam logic [ADDR_W-1:0] ADDR_FLAGS = 3'd7;

  // control register field positions
  localparam int unsigned CTRL_HALT_BIT = 2;
  localparam int unsigned CTRL_MODE_LSB = 4;
endpackage

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit #(
  parameter int unsigned MIN_W  = 7,
  parameter int unsigned HOUR_W = 6,
  parameter int unsigned DAYS   = 7,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned WDAY_W = $clog2(DAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_min_i,
  input  logic              wr_hour_i,
  input  logic              wr_mask_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic              min_tick_i,
  input  logic [MIN_W-1:0]  min_i,
  input  logic [HOUR_W-1:0] hour_i,
  input  logic [WDAY_W-1:0] wday_i,
  output logic [MIN_W-1:0]  min_o,
  output logic [HOUR_W-1:0] hour_o,
  output logic [DAYS-1:0]   mask_o,
  output logic              flag_o
);
  logic [MIN_W-1:0]  min_q;
  logic [HOUR_W-1:0] hour_q;
  logic [DAYS-1:0]   mask_q;
  logic              flag_q;
  logic              day_hit, hit;

  // out-of-range weekday shifts the one-hot off the end: no hit
  assign day_hit = |(mask_q & (DAYS'(1) << wday_i));
  assign hit = min_tick_i && en_i && day_hit &&
               (min_i == min_q) && (hour_i == hour_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min_q  <= '0;
      hour_q <= '0;
      mask_q <= '0;
    end else begin
      if (wr_min_i)  min_q  <= wdata_i[MIN_W-1:0];
      if (wr_hour_i) hour_q <= wdata_i[HOUR_W-1:0];
      if (wr_mask_i) mask_q <= wdata_i[DAYS-1:0];
    end
  end

  // set has priority over a same-cycle host clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (hit)   flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign min_o  = min_q;
  assign hour_o = hour_q;
  assign mask_o = mask_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/rtc_periodic_unit.sv
module rtc_periodic_unit
  import rtc_irq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  per_mode_e mode_i,
  input  logic      halt_i,
  input  logic      half_tick_i,
  input  logic      sec_tick_i,
  input  logic      min_tick_i,
  input  logic      hour_tick_i,
  input  logic      month_tick_i,
  input  logic      clr_i,
  output logic      flag_o,
  output logic      pulse_o,
  output logic      req_o
);
  logic sel_tick, pulse_mode, level_mode;
  logic flag_q, pulse_q;

  always_comb begin
    sel_tick   = 1'b0;
    pulse_mode = 1'b0;
    level_mode = 1'b0;
    case (mode_i)
      PER_HALF_PULSE:  begin sel_tick = half_tick_i;  pulse_mode = 1'b1; end
      PER_SEC_PULSE:   begin sel_tick = sec_tick_i;   pulse_mode = 1'b1; end
      PER_SEC_LEVEL:   begin sel_tick = sec_tick_i;   level_mode = 1'b1; end
      PER_MIN_LEVEL:   begin sel_tick = min_tick_i;   level_mode = 1'b1; end
      PER_HOUR_LEVEL:  begin sel_tick = hour_tick_i;  level_mode = 1'b1; end
      PER_MONTH_LEVEL: begin sel_tick = month_tick_i; level_mode = 1'b1; end
      default:         begin sel_tick = 1'b0; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= sel_tick && pulse_mode;
      if (sel_tick)   flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o  = flag_q;
  assign pulse_o = pulse_q;
  assign req_o   = !halt_i && ((pulse_mode && pulse_q) || (level_mode && flag_q));
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int unsigned MIN_W  = 7,
  parameter int unsigned HOUR_W = 6,
  parameter int unsigned DAYS   = 7,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned WDAY_W = $clog2(DAYS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                half_tick_i,
  input  logic                sec_tick_i,
  input  logic                min_tick_i,
  input  logic                hour_tick_i,
  input  logic                month_tick_i,
  input  logic [MIN_W-1:0]    min_i,
  input  logic [HOUR_W-1:0]   hour_i,
  input  logic [WDAY_W-1:0]   wday_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic                irq_drive_low_o
);
  localparam int unsigned N_ALARM = 2;
  localparam int unsigned N_SRC   = N_ALARM + 1;
  localparam int unsigned PER_BIT = N_ALARM;

  logic [N_ALARM-1:0]             alarm_en_q;
  logic                           halt_q;
  per_mode_e                      mode_q;
  logic                           wr_ctrl, wr_flags;
  logic [N_SRC-1:0]               clr;
  logic [N_SRC-1:0]               flag_vec;
  logic [N_ALARM-1:0][MIN_W-1:0]  al_min;
  logic [N_ALARM-1:0][HOUR_W-1:0] al_hour;
  logic [N_ALARM-1:0][DAYS-1:0]   al_mask;
  logic                           per_pulse, per_req;

  assign wr_ctrl  = reg_we_i && (reg_addr_i == ADDR_CTRL);
  assign wr_flags = reg_we_i && (reg_addr_i == ADDR_FLAGS);
  assign clr      = {N_SRC{wr_flags}} & ~reg_wdata_i[N_SRC-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_en_q <= '0;
      halt_q     <= 1'b0;
      mode_q     <= PER_OFF;
    end else if (wr_ctrl) begin
      alarm_en_q <= reg_wdata_i[N_ALARM-1:0];
      halt_q     <= reg_wdata_i[CTRL_HALT_BIT];
      mode_q     <= per_mode_e'(reg_wdata_i[CTRL_MODE_LSB +: 3]);
    end
  end

  for (genvar c = 0; c < N_ALARM; c++) begin : g_alarm
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(REGS_PER_ALARM * c);
    rtc_alarm_unit #(
      .MIN_W (MIN_W),
      .HOUR_W(HOUR_W),
      .DAYS  (DAYS),
      .DATA_W(DATA_W)
    ) u_alarm (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_min_i  (reg_we_i && (reg_addr_i == BASE)),
      .wr_hour_i (reg_we_i && (reg_addr_i == BASE + ADDR_W'(1))),
      .wr_mask_i (reg_we_i && (reg_addr_i == BASE + ADDR_W'(2))),
      .wdata_i   (reg_wdata_i),
      .en_i      (alarm_en_q[c]),
      .clr_i     (clr[c]),
      .min_tick_i(min_tick_i),
      .min_i     (min_i),
      .hour_i    (hour_i),
      .wday_i    (wday_i),
      .min_o     (al_min[c]),
      .hour_o    (al_hour[c]),
      .mask_o    (al_mask[c]),
      .flag_o    (flag_vec[c])
    );
  end

  rtc_periodic_unit u_per (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_q),
    .halt_i      (halt_q),
    .half_tick_i (half_tick_i),
    .sec_tick_i  (sec_tick_i),
    .min_tick_i  (min_tick_i),
    .hour_tick_i (hour_tick_i),
    .month_tick_i(month_tick_i),
    .clr_i       (clr[PER_BIT]),
    .flag_o      (flag_vec[PER_BIT]),
    .pulse_o     (per_pulse),
    .req_o       (per_req)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_CTRL) begin
      reg_rdata_o[N_ALARM-1:0]          = alarm_en_q;
      reg_rdata_o[CTRL_HALT_BIT]        = halt_q;
      reg_rdata_o[CTRL_MODE_LSB +: 3]   = mode_q;
    end else if (reg_addr_i == ADDR_FLAGS) begin
      reg_rdata_o[N_SRC-1:0] = flag_vec;
    end else begin
      for (int c = 0; c < N_ALARM; c++) begin
        if (reg_addr_i == ADDR_W'(REGS_PER_ALARM * c))
          reg_rdata_o[MIN_W-1:0] = al_min[c];
        if (reg_addr_i == ADDR_W'(REGS_PER_ALARM * c + 1))
          reg_rdata_o[HOUR_W-1:0] = al_hour[c];
        if (reg_addr_i == ADDR_W'(REGS_PER_ALARM * c + 2))
          reg_rdata_o[DAYS-1:0] = al_mask[c];
      end
    end
  end

  assign irq_drive_low_o = (|(flag_vec[N_ALARM-1:0] & alarm_en_q)) || per_req;
endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
module rtc_irq_ctrl_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_i,
  input logic [2:0]        flags_i,
  input logic [1:0]        alarm_en_i,
  input logic              halt_i,
  input logic              per_pulse_i,
  input logic              min_tick_i,
  input logic              reg_we_i,
  input logic [2:0]        reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i
);
  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_release_chk: assert (!irq_i);
    end
  end

  // R7
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_i == 3'b000) |-> !irq_i);

  // R3
  alarm_a_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_i[0]) |-> $past(min_tick_i && alarm_en_i[0]));

  // R5
  alarm_b_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_i[1]) |-> $past(min_tick_i && alarm_en_i[1]));

  // R10
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && ((flags_i[1:0] & alarm_en_i) == 2'b00)) |-> !irq_i);

  // R9
  pulse_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_pulse_i |-> flags_i[2]);

  // R6
  for (genvar k = 0; k < 3; k++) begin : g_sticky
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_i[k] && !(reg_we_i && reg_addr_i == 3'd7 && !reg_wdata_i[k]))
      |=> flags_i[k]);
  end
endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_i      (irq_drive_low_o),
  .flags_i    (flag_vec),
  .alarm_en_i (alarm_en_q),
  .halt_i     (halt_q),
  .per_pulse_i(per_pulse),
  .min_tick_i (min_tick_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i)
);

// File: tb/rtc_irq_ctrl_test.sv
module rtc_irq_ctrl_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       half_t = 0, sec_t = 0, min_t = 0, hour_t = 0, month_t = 0;
  logic [6:0] min_v = '0;
  logic [5:0] hour_v = '0;
  logic [2:0] wday_v = '0;
  logic       we = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  rtc_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .half_tick_i(half_t), .sec_tick_i(sec_t), .min_tick_i(min_t),
    .hour_tick_i(hour_t), .month_tick_i(month_t),
    .min_i(min_v), .hour_i(hour_v), .wday_i(wday_v),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_drive_low_o(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    int       due;
    logic     exp_irq;
    bit       chk_rd;
    logic [7:0] exp_rd;
    string    tag;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // monitor: samples a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #(CLK_P/4);
      while (sb.size() > 0 && sb[0].due <= cyc) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (irq !== it.exp_irq) begin
          fails++;
          $display("FAIL %s irq: actual=%0b expected=%0b", it.tag, irq, it.exp_irq);
        end
        if (it.chk_rd && rdata !== it.exp_rd) begin
          fails++;
          $display("FAIL %s rdata: actual=%02h expected=%02h", it.tag, rdata, it.exp_rd);
        end
      end
    end
  end

  task automatic step();
    @(negedge clk);
    we = 0; half_t = 0; sec_t = 0; min_t = 0; hour_t = 0; month_t = 0;
  endtask

  task automatic expect_irq(input logic e, input string tag);
    item_t it;
    it.due = cyc + 1; it.exp_irq = e; it.chk_rd = 0; it.exp_rd = '0; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic expect_rd(input logic e, input logic [7:0] r, input string tag);
    item_t it;
    it.due = cyc + 1; it.exp_irq = e; it.chk_rd = 1; it.exp_rd = r; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    we = 1; addr = a; wdata = d;
    step();
  endtask

  // read flags one edge after the current stimulus
  task automatic flags_chk(input logic e, input logic [7:0] f, input string tag);
    addr = 3'd7;
    expect_rd(e, f, tag);
    step();
  endtask

  task automatic min_tick_flags(input logic e, input logic [7:0] f, input string tag);
    min_t = 1;
    flags_chk(e, f, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();

    // R1 reset state
    flags_chk(1'b0, 8'h00, "R1 flags");
    addr = 3'd6; expect_rd(1'b0, 8'h00, "R1 ctrl"); step();
    addr = 3'd2; expect_rd(1'b0, 8'h00, "R1 mask"); step();

    // R2 program alarm A: 12:30 on weekday 3
    wr(3'd0, 8'h30); wr(3'd1, 8'h12); wr(3'd2, 8'h08);
    addr = 3'd0; expect_rd(1'b0, 8'h30, "R2 A minute"); step();
    addr = 3'd1; expect_rd(1'b0, 8'h12, "R2 A hour"); step();
    addr = 3'd2; expect_rd(1'b0, 8'h08, "R2 A mask"); step();
    wr(3'd6, 8'h01);
    addr = 3'd6; expect_rd(1'b0, 8'h01, "R2 ctrl"); step();

    wday_v = 3'd3; hour_v = 6'h12; min_v = 7'h30;
    flags_chk(1'b0, 8'h00, "R3 no tick no flag");
    min_tick_flags(1'b1, 8'h01, "R3 match sets A");
    flags_chk(1'b1, 8'h01, "R6 sticky");
    wr(3'd7, 8'h00);
    flags_chk(1'b0, 8'h00, "R6 clear");

    // R3/R4 mismatches
    wday_v = 3'd4;
    min_tick_flags(1'b0, 8'h00, "R4 weekday not in mask");
    wday_v = 3'd3; hour_v = 6'h11;
    min_tick_flags(1'b0, 8'h00, "R3 hour mismatch");
    hour_v = 6'h12; min_v = 7'h31;
    min_tick_flags(1'b0, 8'h00, "R3 minute mismatch");
    min_v = 7'h30;

    // R4 multi-day mask: days 0 and 4
    wr(3'd2, 8'h11);
    wday_v = 3'd4;
    min_tick_flags(1'b1, 8'h01, "R4 day 4 in mask");
    wr(3'd7, 8'h00);
    wday_v = 3'd0;
    min_tick_flags(1'b1, 8'h01, "R4 day 0 in mask");
    wr(3'd7, 8'h00);
    wday_v = 3'd3;
    min_tick_flags(1'b0, 8'h00, "R4 day 3 dropped");
    wr(3'd2, 8'h08);

    // R5 channel B, disabled then enabled
    wr(3'd3, 8'h30); wr(3'd4, 8'h12); wr(3'd5, 8'h08);
    min_tick_flags(1'b1, 8'h01, "R5 B disabled stays clear");
    wr(3'd7, 8'h00);
    wr(3'd6, 8'h02);
    min_tick_flags(1'b1, 8'h02, "R5 B alone");
    wr(3'd6, 8'h03);
    min_tick_flags(1'b1, 8'h03, "R5 both");
    wr(3'd7, 8'h01);
    flags_chk(1'b1, 8'h01, "R6 per-bit clear");

    // R7 enable gates the line, flag kept
    wr(3'd6, 8'h02);
    flags_chk(1'b0, 8'h01, "R7 disabled releases line");
    wr(3'd7, 8'h00);

    // R11 set beats clear
    wr(3'd6, 8'h01);
    we = 1; addr = 3'd7; wdata = 8'h00; min_t = 1;
    step();
    flags_chk(1'b1, 8'h01, "R11 set wins");
    wr(3'd7, 8'h00);

    // periodic, alarms off
    wr(3'd6, 8'h20);
    sec_t = 1; addr = 3'd7;
    expect_rd(1'b1, 8'h04, "R9 sec pulse cycle"); step();
    expect_rd(1'b0, 8'h04, "R9 pulse ends flag kept"); step();
    wr(3'd7, 8'h00);
    half_t = 1;
    flags_chk(1'b0, 8'h00, "R8 mode 2 ignores half tick");

    wr(3'd6, 8'h24);
    sec_t = 1;
    flags_chk(1'b0, 8'h04, "R10 halted pulse");
    wr(3'd7, 8'h00);

    wr(3'd6, 8'h10);
    half_t = 1; addr = 3'd7;
    expect_rd(1'b1, 8'h04, "R8 half pulse"); step();
    expect_irq(1'b0, "R9 half pulse one cycle"); step();
    wr(3'd7, 8'h00);

    wr(3'd6, 8'h30);
    sec_t = 1;
    flags_chk(1'b1, 8'h04, "R9 sec level");
    flags_chk(1'b1, 8'h04, "R9 level holds");
    flags_chk(1'b1, 8'h04, "R9 level still holds");
    wr(3'd7, 8'h00);
    flags_chk(1'b0, 8'h00, "R9 level cleared");

    wr(3'd6, 8'h40);
    sec_t = 1;
    flags_chk(1'b0, 8'h00, "R8 mode 4 ignores sec");
    min_tick_flags(1'b1, 8'h04, "R8 minute level");
    wr(3'd7, 8'h00);

    wr(3'd6, 8'h50);
    hour_t = 1;
    flags_chk(1'b1, 8'h04, "R8 hour level");
    wr(3'd7, 8'h00);

    wr(3'd6, 8'h60);
    min_t = 1; sec_t = 1;
    flags_chk(1'b0, 8'h00, "R8 mode 6 ignores others");
    month_t = 1;
    flags_chk(1'b1, 8'h04, "R8 month level");
    wr(3'd7, 8'h00);

    wr(3'd6, 8'h70);
    half_t = 1; sec_t = 1; min_t = 1; hour_t = 1; month_t = 1;
    flags_chk(1'b0, 8'h00, "R8 mode 7 inert");
    wr(3'd6, 8'h00);
    half_t = 1; sec_t = 1; min_t = 1; hour_t = 1; month_t = 1;
    flags_chk(1'b0, 8'h00, "R8 mode 0 inert");

    // R10 halt then release in level mode
    wr(3'd6, 8'h44);
    min_tick_flags(1'b0, 8'h04, "R10 halted level");
    wr(3'd6, 8'h40);
    flags_chk(1'b1, 8'h04, "R10 release drives");
    wr(3'd7, 8'h00);
    flags_chk(1'b0, 8'h00, "R6 final clear");

    repeat (3) step();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule